// File: doc/BRIEF.md
# Sequential Shift-Subtract Unsigned Divider

This block divides an unsigned double-width dividend, given as an upper and a lower word, by a single-width divisor. It finds one quotient bit per clock with restoring shift-subtract steps. A pulse on `startIn` while the block is idle captures the operands. The block then spends one cycle per quotient bit. When it finishes, the quotient is on `quoOut`, the remainder is on `remOut`, and `done` pulses for one cycle.

On each step, the upper and lower registers shift left together as one double-width value. The bit that falls out of the top of the upper word is kept. That bit is combined with an unsigned compare of the shifted upper word against the divisor to decide the quotient bit. With this, a partial remainder that briefly needs one extra bit is still handled correctly. The new quotient bit enters the bottom of the lower word, so the lower word holds the quotient once all steps are done.

A quotient only fits in one word when the upper dividend word is smaller than the divisor. If it is not, the block raises `overflow` at start and skips the iteration. A zero divisor is one case of this.

Top module: `seqDivider`

## Requirements
- R1: After reset, `busy`, `done` and `overflow` are 0, and `quoOut` and `remOut` are 0.
- R2: A start while idle with `dividendHi < divisor` raises `busy` on the next cycle and keeps it high for exactly W cycles (W = 32 by default).
- R3: `done` is high for exactly one cycle, the cycle after `busy` falls. At that point `quoOut` equals floor({dividendHi,dividendLo} / divisor).
- R4: When `done` follows a division, `remOut` equals {dividendHi,dividendLo} mod divisor and is below the divisor.
- R5: A start with `dividendHi >= divisor` (which includes divisor 0) sets `overflow` to 1 and leaves `busy` low. `done` pulses on the next cycle, with `remOut` = dividendHi and `quoOut` = dividendLo.
- R6: `overflow` holds its value until the next accepted start, and a start that does not overflow clears it to 0.
- R7: A start while `busy` is high is ignored, and the running division finishes with its original operands.
- R8: While idle, `quoOut`, `remOut` and `overflow` keep the last result until the next accepted start.
- R9: The quotient is correct when the shifted partial remainder needs W+1 bits. For example, {32'hFFFFFFFE,32'hFFFFFFFF} / 32'hFFFFFFFF gives quotient 32'hFFFFFFFF and remainder 32'hFFFFFFFE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| startIn | input | 1 | Start request, taken only when idle |
| dividendHi | input | W | Upper dividend word |
| dividendLo | input | W | Lower dividend word |
| divisor | input | W | Divisor |
| busy | output | 1 | Division steps in progress |
| done | output | 1 | One-cycle result strobe |
| overflow | output | 1 | Quotient would not fit in W bits |
| remOut | output | W | Remainder, or upper dividend word after overflow |
| quoOut | output | W | Quotient, or lower dividend word after overflow |

## Verification
The assertions on the partial remainder rely on the divisor staying fixed during a run and on a run starting only when the upper word is below the divisor. Both hold because operands are latched only on an accepted start, and an overflowing start never enters the stepping state. The stimulus changes inputs only away from the rising edge. It includes operands that trigger the overflow path (equal upper word and divisor, and a zero divisor) as well as divisors near full scale. It also issues one start while a division is running.

// File: rtl/divPkg.sv
package divPkg;
  typedef struct packed {
    logic load;   // capture operands and overflow decision
    logic step;   // perform one shift-subtract iteration
  } divStrobe_t;
endpackage

// File: rtl/divCtrl.sv
module divCtrl
  import divPkg::*;
#(
  parameter int W = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startIn,
  input  logic       ovfNow,
  output divStrobe_t ctl,
  output logic       busy,
  output logic       done
);
  localparam int CW = $clog2(W + 1);

  logic          busyQ;
  logic          doneQ;
  logic [CW-1:0] cntQ;

  always_comb begin
    ctl.load = startIn && !busyQ;
    ctl.step = busyQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      doneQ <= 1'b0;
      cntQ  <= '0;
    end else begin
      doneQ <= 1'b0;
      if (ctl.load) begin
        if (ovfNow) begin
          doneQ <= 1'b1;
        end else begin
          busyQ <= 1'b1;
          cntQ  <= CW'(W);
        end
      end else if (busyQ) begin
        cntQ <= cntQ - 1'b1;
        if (cntQ == CW'(1)) begin
          busyQ <= 1'b0;
          doneQ <= 1'b1;
        end
      end
    end
  end

  assign busy = busyQ;
  assign done = doneQ;

  // R3: result strobe lasts a single cycle
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3: end of stepping is always followed by a strobe
  assert_busy_end_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R5: an overflowing start strobes at once and never steps
  assert_ovf_skip_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && ovfNow) |=> (done && !busy));
endmodule

// File: rtl/divPath.sv
module divPath
  import divPkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  divStrobe_t   ctl,
  input  logic [W-1:0] hiIn,
  input  logic [W-1:0] loIn,
  input  logic [W-1:0] divisorIn,
  output logic         ovfNow,
  output logic [W-1:0] hiOut,
  output logic [W-1:0] loOut,
  output logic         ovfOut
);
  logic [W-1:0] hiQ;
  logic [W-1:0] loQ;
  logic [W-1:0] divQ;
  logic         ovfQ;

  logic         hiMsb;
  logic [W-1:0] hiSh;
  logic         qBit;
  logic [W-1:0] hiNext;

  always_comb begin
    ovfNow = (hiIn >= divisorIn);
    hiMsb  = hiQ[W-1];
    hiSh   = {hiQ[W-2:0], loQ[W-1]};
    qBit   = hiMsb || (hiSh >= divQ);
    hiNext = qBit ? (hiSh - divQ) : hiSh;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiQ  <= '0;
      loQ  <= '0;
      divQ <= '0;
      ovfQ <= 1'b0;
    end else if (ctl.load) begin
      hiQ  <= hiIn;
      loQ  <= loIn;
      divQ <= divisorIn;
      ovfQ <= ovfNow;
    end else if (ctl.step) begin
      hiQ <= hiNext;
      loQ <= {loQ[W-2:0], qBit};
    end
  end

  assign hiOut  = hiQ;
  assign loOut  = loQ;
  assign ovfOut = ovfQ;

  // R5: stepping only happens for a run that did not overflow
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |-> !ovfQ);

  // R4: partial remainder stays below the divisor after every step
  assert_rem_below_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |=> (hiQ < divQ));

  // R7: divisor is held through a run
  assert_div_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |=> $stable(divQ));

  // R9: when the top bit falls out, the wrapped shift is below the divisor
  assert_wide_rem_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && hiMsb) |-> (hiSh < divQ));
endmodule

// File: rtl/seqDivider.sv
module seqDivider
  import divPkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startIn,
  input  logic [W-1:0] dividendHi,
  input  logic [W-1:0] dividendLo,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic         overflow,
  output logic [W-1:0] remOut,
  output logic [W-1:0] quoOut
);
  divStrobe_t ctl;
  logic       ovfNow;

  divCtrl #(.W(W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .startIn (startIn),
    .ovfNow  (ovfNow),
    .ctl     (ctl),
    .busy    (busy),
    .done    (done)
  );

  divPath #(.W(W)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .hiIn      (dividendHi),
    .loIn      (dividendLo),
    .divisorIn (divisor),
    .ovfNow    (ovfNow),
    .hiOut     (remOut),
    .loOut     (quoOut),
    .ovfOut    (overflow)
  );
endmodule

// File: tb/sim_seqDivider.sv
module sim_seqDivider;
  localparam int W      = 32;
  localparam int PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] dHi = '0, dLo = '0, dDiv = '0;
  logic         busy, done, overflow;
  logic [W-1:0] remOut, quoOut;

  int totalCnt = 0;
  int failCnt  = 0;

  // reference model state
  logic         mBusy, mDone, mOvf;
  logic [W-1:0] mHi, mLo;
  int           mCnt;

  always #(PERIOD/2) clk = ~clk;

  seqDivider #(.W(W)) u0 (
    .clk(clk), .rstN(rstN), .startIn(start),
    .dividendHi(dHi), .dividendLo(dLo), .divisor(dDiv),
    .busy(busy), .done(done), .overflow(overflow),
    .remOut(remOut), .quoOut(quoOut)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    totalCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural model, advanced on each rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      mBusy <= 1'b0; mDone <= 1'b0; mOvf <= 1'b0;
      mHi <= '0; mLo <= '0; mCnt <= 0;
    end else begin
      mDone <= 1'b0;
      if (start && !mBusy) begin
        if (dHi >= dDiv) begin
          mOvf <= 1'b1; mDone <= 1'b1; mHi <= dHi; mLo <= dLo;
        end else begin
          mOvf  <= 1'b0;
          mBusy <= 1'b1;
          mCnt  <= W;
          mHi   <= W'({dHi, dLo} % {32'd0, dDiv});
          mLo   <= W'({dHi, dLo} / {32'd0, dDiv});
        end
      end else if (mBusy) begin
        mCnt <= mCnt - 1;
        if (mCnt == 1) begin
          mBusy <= 1'b0;
          mDone <= 1'b1;
        end
      end
    end
  end

  // compare on every clock, away from the rising edge
  always @(negedge clk) begin
    if (rstN) begin
      chk("R2 busy", 64'(busy), 64'(mBusy));
      chk("R3 done", 64'(done), 64'(mDone));
      if (!mBusy) begin
        chk(mDone ? "R3 quotient" : "R8 quotient held", 64'(quoOut), 64'(mLo));
        chk(mDone ? "R4 remainder" : "R8 remainder held", 64'(remOut), 64'(mHi));
        chk(mOvf ? "R5 overflow" : "R6 overflow", 64'(overflow), 64'(mOvf));
      end
    end
  end

  task automatic runDiv(input logic [W-1:0] hi, input logic [W-1:0] lo, input logic [W-1:0] dv);
    @(negedge clk);
    dHi = hi; dLo = lo; dDiv = dv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (W + 4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 done", 64'(done), 64'd0);
    chk("R1 overflow", 64'(overflow), 64'd0);
    chk("R1 quotient", 64'(quoOut), 64'd0);
    chk("R1 remainder", 64'(remOut), 64'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    runDiv(32'd0, 32'd100, 32'd7);
    runDiv(32'd5, 32'h89ABCDEF, 32'd9);
    runDiv(32'd0, 32'hFFFFFFFF, 32'd1);
    runDiv(32'h12345678, 32'h9ABCDEF0, 32'h80000001);

    // R9: shifted partial remainder needs an extra bit
    runDiv(32'hFFFFFFFE, 32'hFFFFFFFF, 32'hFFFFFFFF);
    chk("R9 quotient", 64'(quoOut), 64'hFFFFFFFF);
    chk("R9 remainder", 64'(remOut), 64'hFFFFFFFE);

    // R5: upper word equal to divisor, then zero divisor
    runDiv(32'd9, 32'd1, 32'd9);
    chk("R5 overflow flag", 64'(overflow), 64'd1);
    runDiv(32'd0, 32'd77, 32'd0);
    chk("R5 zero divisor", 64'(overflow), 64'd1);
    chk("R5 lower word kept", 64'(quoOut), 64'd77);

    // R6: clean start clears the flag
    runDiv(32'd1, 32'd0, 32'd3);
    chk("R6 overflow cleared", 64'(overflow), 64'd0);

    // R7: second start during a run is ignored
    @(negedge clk);
    dHi = 32'd0; dLo = 32'd1000; dDiv = 32'd7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    dHi = 32'd0; dLo = 32'd9; dDiv = 32'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (W + 4) @(negedge clk);
    chk("R7 quotient", 64'(quoOut), 64'd142);
    chk("R7 remainder", 64'(remOut), 64'd6);

    // R8: hold after many idle cycles
    repeat (10) @(negedge clk);
    chk("R8 quotient hold", 64'(quoOut), 64'd142);

    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end

  initial begin
    #(PERIOD * 50000);
    totalCnt++;
    failCnt++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end
endmodule